// File: doc/BRIEF.md
# ADC Sample Window Timer

This block times the acquisition window of a successive-approximation converter front end. It divides the system clock by one of eight selectable ratios and emits a one-cycle ADC clock enable on each divided tick. The timer then drives a sample-window output in one of two ways. In timed mode the window lasts a programmed number of ADC ticks. In manual mode the window opens on a software start strobe and closes only on a software stop strobe.

A trigger may come from software or from a hardware event line. Some pairings of window mode and trigger source are not allowed. When the pairing is illegal, a configuration-error output rises and the block ignores every start request until the pairing is fixed. A one-cycle completion pulse marks the end of each window. The converter core and the register file that drives the configuration inputs sit outside this block.

Top module: `adc_sample_timer`

## Requirements
- R1: `div_sel` picks the divide ratio: 0→1, 1→2, 2→4, 3→8, 4→16, 5→24, 6→32, 7→48. While `div_sel` is held, `adc_clk_en` is high for exactly one system cycle in every ratio cycles.
- R2: A change of `div_sel` restarts the divider. If the new value is first sampled at edge k, `adc_clk_en` is low after edge k, and the first new tick appears after edge k+ratio.
- R3: Timed mode (`manual_mode`=0) accepts a trigger while idle. The trigger is `sw_start` when `sw_src`=1 and `hw_event` when `sw_src`=0. `sample_active` rises on the edge that samples the trigger. It falls on the edge where the Nth `adc_clk_en` pulse seen while it is high is sampled, where N is `smp_count`.
- R4: In timed mode a `smp_count` of 0 gives the same window as 1, so the window ends on the first tick.
- R5: Manual mode (`manual_mode`=1, `sw_src`=1) opens the window on `sw_start`. The window stays open for any number of cycles and closes on the edge that samples `sw_stop`.
- R6: `cfg_err` is registered. One edge after the inputs are sampled it reads 1 exactly when `manual_mode`=1 and `sw_src`=0, and 0 otherwise.
- R7: While that illegal pairing is applied, `sw_start`, `sw_stop` and `hw_event` start no window.
- R8: `hw_event` starts nothing when `sw_src`=1. `sw_start` starts nothing in timed mode when `sw_src`=0.
- R9: `sample_done` is a single-cycle pulse. It is high exactly in the cycle after the edge where `sample_active` falls, and at no other time.
- R10: Start strobes during an open window are ignored. `sw_stop` has no effect on a timed window.
- R11: After reset, `adc_clk_en`, `sample_active`, `sample_done` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Divide ratio code |
| smp_count | input | 14 | Window length in ADC ticks (timed mode) |
| manual_mode | input | 1 | 1 = window bounded by start/stop strobes |
| sw_src | input | 1 | 1 = software trigger source, 0 = hardware event |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software stop strobe |
| hw_event | input | 1 | Hardware trigger event |
| adc_clk_en | output | 1 | One-cycle ADC clock tick |
| sample_active | output | 1 | Sample window open |
| sample_done | output | 1 | Window-complete pulse |
| cfg_err | output | 1 | Illegal mode/source pairing |

## Verification
The window properties assume that `manual_mode`, `sw_src` and `smp_count` stay fixed while a window is open. Under that assumption the live mode input matches the mode captured at the start. The stimulus sets every configuration field at a falling edge before a window begins and leaves them untouched until the completion pulse has gone by. Changes of the divide code also happen only between windows. Strobes are single-cycle pulses, and some are applied on purpose during open windows and under the illegal pairing.

// File: rtl/adc_smp_pkg.sv
package adc_smp_pkg;

  localparam int SEL_W    = 3;
  localparam int MAX_DIV  = 48;
  localparam int DIV_CW   = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TIMED  = 2'd1,
    ST_MANUAL = 2'd2
  } win_state_e;

  function automatic int div_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      3'd4:    return 16;
      3'd5:    return 24;
      3'd6:    return 32;
      default: return 48;
    endcase
  endfunction

endpackage

// File: rtl/adc_div_tick.sv
module adc_div_tick
  import adc_smp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [SEL_W-1:0]  sel_q;
  logic [DIV_CW-1:0] cnt_q;
  logic [DIV_CW-1:0] last_val;

  always_comb last_val = DIV_CW'(div_ratio(sel) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= sel;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      sel_q <= sel;
      if (sel != sel_q) begin
        cnt_q <= '0;
        tick  <= 1'b0;
      end else if (cnt_q == last_val) begin
        cnt_q <= '0;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tick  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_cfg_check.sv
module adc_cfg_check (
  input  logic clk,
  input  logic rst,
  input  logic manual_mode,
  input  logic sw_src,
  input  logic sw_start,
  input  logic hw_event,
  output logic start_timed,
  output logic start_manual,
  output logic cfg_err
);

  logic bad_pair;

  always_comb begin
    bad_pair     = manual_mode & ~sw_src;
    start_manual = manual_mode & sw_src & sw_start;
    start_timed  = ~manual_mode & (sw_src ? sw_start : hw_event);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad_pair;
  end

endmodule

// File: rtl/adc_win_fsm.sv
module adc_win_fsm
  import adc_smp_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             start_timed,
  input  logic             start_manual,
  input  logic             stop,
  output logic             active,
  output logic             done
);

  win_state_e       st_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] load_val;

  always_comb load_val = (count == '0) ? CNT_W'(1) : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_manual) begin
            st_q   <= ST_MANUAL;
            active <= 1'b1;
          end else if (start_timed) begin
            st_q   <= ST_TIMED;
            rem_q  <= load_val;
            active <= 1'b1;
          end
        end
        ST_TIMED: begin
          if (tick) begin
            if (rem_q == CNT_W'(1)) begin
              st_q   <= ST_IDLE;
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              rem_q <= rem_q - 1'b1;
            end
          end
        end
        ST_MANUAL: begin
          if (stop) begin
            st_q   <= ST_IDLE;
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_sample_timer.sv
module adc_sample_timer
  import adc_smp_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0] smp_count,
  input  logic             manual_mode,
  input  logic             sw_src,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             hw_event,
  output logic             adc_clk_en,
  output logic             sample_active,
  output logic             sample_done,
  output logic             cfg_err
);

  logic start_timed;
  logic start_manual;

  adc_div_tick u_div (
    .clk  (clk),
    .rst  (rst),
    .sel  (div_sel),
    .tick (adc_clk_en)
  );

  adc_cfg_check u_cfg (
    .clk          (clk),
    .rst          (rst),
    .manual_mode  (manual_mode),
    .sw_src       (sw_src),
    .sw_start     (sw_start),
    .hw_event     (hw_event),
    .start_timed  (start_timed),
    .start_manual (start_manual),
    .cfg_err      (cfg_err)
  );

  adc_win_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick         (adc_clk_en),
    .count        (smp_count),
    .start_timed  (start_timed),
    .start_manual (start_manual),
    .stop         (sw_stop),
    .active       (sample_active),
    .done         (sample_done)
  );

endmodule

// File: rtl/adc_sample_timer_chk.sv
module adc_sample_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] div_sel,
  input logic       manual_mode,
  input logic       sw_src,
  input logic       sw_start,
  input logic       sw_stop,
  input logic       hw_event,
  input logic       adc_clk_en,
  input logic       sample_active,
  input logic       sample_done,
  input logic       cfg_err
);

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (rst)
    (div_sel != $past(div_sel)) |=> !adc_clk_en);  // R2

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (manual_mode && !sw_src) |=> cfg_err);  // R6

  AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_active) |-> !$past(manual_mode && !sw_src));  // R7

  AST_START_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_active) |-> $past(sw_src ? sw_start : (hw_event && !manual_mode)));  // R8

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    sample_done |-> (!sample_active && $past(sample_active)));  // R9

  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_active) |-> sample_done);  // R9

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sample_active && manual_mode && sw_src && !sw_stop) |=> sample_active);  // R5

endmodule

bind adc_sample_timer adc_sample_timer_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .div_sel       (div_sel),
  .manual_mode   (manual_mode),
  .sw_src        (sw_src),
  .sw_start      (sw_start),
  .sw_stop       (sw_stop),
  .hw_event      (hw_event),
  .adc_clk_en    (adc_clk_en),
  .sample_active (sample_active),
  .sample_done   (sample_done),
  .cfg_err       (cfg_err)
);

// File: tb/adc_sample_timer_tb.sv
module adc_sample_timer_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  div_sel;
  logic [13:0] smp_count;
  logic        manual_mode, sw_src, sw_start, sw_stop, hw_event;
  logic        adc_clk_en, sample_active, sample_done, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  adc_sample_timer u_dut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .smp_count(smp_count),
    .manual_mode(manual_mode), .sw_src(sw_src), .sw_start(sw_start),
    .sw_stop(sw_stop), .hw_event(hw_event), .adc_clk_en(adc_clk_en),
    .sample_active(sample_active), .sample_done(sample_done), .cfg_err(cfg_err)
  );

  function automatic int ratio_of(input logic [2:0] s);
    int t[8] = '{1, 2, 4, 8, 16, 24, 32, 48};
    return t[s];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic check_div(input logic [2:0] s);
    int r = ratio_of(s);
    int n = 0;
    int g;
    div_sel = s;
    do begin step(); n++; end while (!adc_clk_en && n < 200);
    chk(n == r + 1, $sformatf("R2 first tick sel=%0d", s), n, r + 1);
    for (int k = 0; k < 2; k++) begin
      g = 0;
      do begin step(); g++; end while (!adc_clk_en && g < 200);
      chk(g == r, $sformatf("R1 tick gap sel=%0d", s), g, r);
    end
  endtask

  task automatic run_timed(input logic [2:0] s, input int cnt, input bit use_hw, input bit poke);
    int ticks = 0, w = 0, exp_t;
    bit last_en = 0;
    div_sel = s; smp_count = 14'(cnt); manual_mode = 0; sw_src = !use_hw;
    repeat (3) step();
    if (use_hw) hw_event = 1; else sw_start = 1;
    step();
    hw_event = 0; sw_start = 0;
    chk(sample_active, "R3 window opens", sample_active, 1);
    exp_t = (cnt == 0) ? 1 : cnt;
    while (sample_active && w < 5000) begin
      if (adc_clk_en) ticks++;
      last_en = adc_clk_en;
      if (poke && w == 1) begin sw_stop = 1; sw_start = 1; hw_event = 1; end
      step();
      sw_stop = 0; sw_start = 0; hw_event = 0;
      w++;
    end
    chk(ticks == exp_t, cnt == 0 ? "R4 zero count ticks" : (poke ? "R10 window ticks" : "R3 window ticks"), ticks, exp_t);
    chk(last_en, "R3 ends on tick", last_en, 1);
    chk(sample_done, "R9 done at fall", sample_done, 1);
    step();
    chk(!sample_done && !sample_active, "R9 done single cycle", sample_done, 0);
  endtask

  task automatic run_manual(input int len);
    manual_mode = 1; sw_src = 1;
    repeat (2) step();
    sw_start = 1; step(); sw_start = 0;
    chk(sample_active, "R5 manual opens", sample_active, 1);
    for (int k = 0; k < len; k++) begin
      if (k == 1) sw_start = 1;
      step();
      sw_start = 0;
      chk(sample_active && !sample_done, "R5 manual held", sample_active, 1);
    end
    sw_stop = 1; step(); sw_stop = 0;
    chk(!sample_active, "R5 manual closes", sample_active, 0);
    chk(sample_done, "R9 manual done", sample_done, 1);
    step();
    chk(!sample_done, "R9 manual done single", sample_done, 0);
    manual_mode = 0;
  endtask

  initial begin
    bit quiet;
    void'($urandom(32'h5eed_0042));
    rst = 1; div_sel = 0; smp_count = 0; manual_mode = 0; sw_src = 1;
    sw_start = 0; sw_stop = 0; hw_event = 0;
    repeat (3) step();
    chk(!adc_clk_en && !sample_active && !sample_done && !cfg_err, "R11 reset state",
        {adc_clk_en, sample_active, sample_done, cfg_err}, 0);
    rst = 0;
    step();

    for (int s = 7; s >= 0; s--) check_div(3'(s));
    check_div(3'd5);

    run_timed(3'd0, 5, 0, 0);
    run_timed(3'd2, 0, 1, 0);
    run_timed(3'd5, 1, 0, 0);
    run_timed(3'd0, 300, 1, 0);
    run_timed(3'd1, 6, 0, 1);
    run_manual(7);
    run_manual(0);

    manual_mode = 1; sw_src = 0;
    step(); step();
    chk(cfg_err, "R6 error flag set", cfg_err, 1);
    quiet = 1;
    for (int k = 0; k < 6; k++) begin
      sw_start = (k % 3 == 0); sw_stop = (k % 3 == 1); hw_event = (k % 3 == 2);
      step();
      if (sample_active) quiet = 0;
    end
    sw_start = 0; sw_stop = 0; hw_event = 0;
    step();
    chk(quiet && !sample_active, "R7 no start on error", sample_active, 0);
    sw_src = 1; step();
    chk(!cfg_err, "R6 error flag clear", cfg_err, 1'b0);
    manual_mode = 0;

    sw_src = 1; hw_event = 1; step(); hw_event = 0; step();
    chk(!sample_active, "R8 event ignored with sw source", sample_active, 0);
    sw_src = 0; sw_start = 1; step(); sw_start = 0; step();
    chk(!sample_active, "R8 sw start ignored with hw source", sample_active, 0);

    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 4) == 0) run_manual(int'($urandom_range(0, 12)));
      else run_timed(3'($urandom_range(0, 7)), int'($urandom_range(0, 12)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finish_run();
  end

endmodule